// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet-style MAC, directly after the deserialiser. It watches the opening bytes of each incoming frame, which carry the destination address. It compares those bytes against a programmed station address and also checks them for the all-ones broadcast address. Once the address has fully arrived, it emits a single accept or reject pulse.

A two-bit policy input selects how strict the filter is. The choices are: drop everything, take only frames sent to this station, take frames sent to this station plus broadcasts, or take everything. The policy is captured when a frame starts, so software can reprogram it at any time without disturbing a frame already in flight. If a frame is cut short before its address is complete, a reject is issued for it, so every started frame receives exactly one verdict.

Top module: `rx_dest_filter`

## Requirements
- R1: Byte i of `station_addr` (bits 8i+7..8i) is compared with the i-th valid byte of a frame, where the byte marked by `in_sof` is byte 0.
- R2: With `accept_mode` = 0, every frame gets a reject pulse and no accept pulse.
- R3: With `accept_mode` = 1, a frame is accepted only if all six address bytes equal the station address; any other frame is rejected, including a broadcast.
- R4: With `accept_mode` = 2, a frame is accepted if it matches the station address or if all six address bytes are 0xFF; any other frame is rejected.
- R5: With `accept_mode` = 3, every frame that delivers six address bytes is accepted.
- R6: The verdict for a complete address is one pulse, one cycle long, on `accept_o` or `reject_o`, in the cycle after the sixth valid byte. The two outputs are never high together.
- R7: If a byte marked `in_sof` arrives while fewer than six bytes of the current frame have been seen, `reject_o` pulses in the following cycle for the truncated frame. That byte then starts a new frame as byte 0.
- R8: `accept_mode` is captured on the start byte; changes during the rest of the frame do not alter that frame's verdict.
- R9: Cycles with `in_valid` low are skipped without effect, and valid bytes are ignored if they arrive without `in_sof` when no frame is open, or after the sixth byte. Neither kind of cycle produces a pulse.
- R10: While `rst_n` is low at a clock edge, both outputs go low and any open frame is discarded, so later bytes without `in_sof` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_sof | input | 1 | The present byte is the first of a frame |
| in_byte | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7..0 |
| accept_mode | input | 2 | 0 none, 1 station only, 2 station or broadcast, 3 all |
| accept_o | output | 1 | One-cycle accept pulse |
| reject_o | output | 1 | One-cycle reject pulse |

## Verification
A byte counter that slips would cause the wrong station byte to be compared. At the ports, this appears as a wrong verdict, or as a pulse that arrives a cycle early or late, in the cycle after what should have been the sixth byte. A stuck match flag appears in that same cycle as an accept that should have been a reject, or the reverse. A lost open-frame flag shows up one cycle after the next start byte: the truncated frame either gets no reject, or gets an extra one. A mode register loaded at the wrong time is exposed only by frames whose policy changes mid-frame, and the error appears on that frame's verdict.

// File: rtl/rxf_pkg.sv
// Shared definitions for the receive destination filter.
package rxf_pkg;
    // Accept policy; encodings are fixed by the programming model.
    typedef enum logic [1:0] {
        ACC_NONE      = 2'd0,
        ACC_STATION   = 2'd1,
        ACC_STN_BCAST = 2'd2,
        ACC_ALL       = 2'd3
    } acc_mode_e;

    localparam logic [7:0] BCAST_BYTE = 8'hFF;
endpackage

// File: rtl/rxf_frame_track.sv
// Frame position tracker: tells which address byte is on the bus.
// Assumes ADDR_BYTES >= 2; a start byte is always byte 0 of a new frame.
module rxf_frame_track #(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic [CW-1:0] byte_idx,
    output logic          first_beat,
    output logic          addr_beat,
    output logic          last_beat,
    output logic          short_abort,
    output logic          frame_open
);
    logic          open_q;
    logic [CW-1:0] cnt_q;

    // Classify the current cycle from the input qualifiers and state.
    always_comb begin
        first_beat  = in_valid && in_sof;
        addr_beat   = first_beat || (in_valid && open_q);
        byte_idx    = first_beat ? '0 : cnt_q;
        last_beat   = addr_beat && (byte_idx == CW'(ADDR_BYTES - 1));
        short_abort = first_beat && open_q;
    end

    // Advance the address byte count; close the frame after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (addr_beat) begin
            if (last_beat) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                open_q <= 1'b1;
                cnt_q  <= byte_idx + 1'b1;
            end
        end
    end

    assign frame_open = open_q;
endmodule

// File: rtl/rxf_addr_match.sv
// Running comparators: station-address match and broadcast detection.
// Hit outputs describe the whole address and are meaningful on last_beat.
module rxf_addr_match
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              in_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic [CW-1:0]           byte_idx,
    input  logic                    addr_beat,
    input  logic                    first_beat,
    output logic                    stn_hit,
    output logic                    bc_hit
);
    logic [ADDR_BYTES-1:0] eq_vec;
    logic                  eq_now;
    logic                  stn_run_q;
    logic                  bc_run_q;

    // One comparator per station byte.
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
        assign eq_vec[i] = (in_byte == station_addr[8*i +: 8]);
    end

    // Pick the comparator for the byte position now on the bus.
    always_comb begin
        eq_now = 1'b0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (byte_idx == CW'(i)) eq_now = eq_vec[i];
        end
    end

    // Fold this byte into the running results; a start byte restarts them.
    always_comb begin
        stn_hit = (first_beat || stn_run_q) && eq_now;
        bc_hit  = (first_beat || bc_run_q) && (in_byte == BCAST_BYTE);
    end

    // Hold the running results between address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stn_run_q <= 1'b0;
            bc_run_q  <= 1'b0;
        end else if (addr_beat) begin
            stn_run_q <= stn_hit;
            bc_run_q  <= bc_hit;
        end
    end
endmodule

// File: rtl/rxf_verdict.sv
// Policy stage: captures the mode per frame and registers the verdict pulse.
// Assumes short_abort and last_beat are never high together (ADDR_BYTES >= 2).
module rxf_verdict
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      first_beat,
    input  logic      last_beat,
    input  logic      short_abort,
    input  acc_mode_e mode_in,
    input  logic      stn_hit,
    input  logic      bc_hit,
    output logic      accept_o,
    output logic      reject_o,
    output acc_mode_e mode_hold
);
    acc_mode_e mode_q;
    acc_mode_e mode_eff;
    logic      take;

    // Apply the frame's policy to the address results.
    always_comb begin
        mode_eff = first_beat ? mode_in : mode_q;
        unique case (mode_eff)
            ACC_NONE:      take = 1'b0;
            ACC_STATION:   take = stn_hit;
            ACC_STN_BCAST: take = stn_hit || bc_hit;
            ACC_ALL:       take = 1'b1;
            default:       take = 1'b0;
        endcase
    end

    // Capture the policy on each start byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q <= ACC_NONE;
        else if (first_beat) mode_q <= mode_in;
    end

    // Register one-cycle verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_o <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            accept_o <= last_beat && take;
            reject_o <= short_abort || (last_beat && !take);
        end
    end

    assign mode_hold = mode_q;
endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter top: tracks the address bytes of each
// frame, matches them, and pulses accept or reject after the last one.
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES + 1),
    localparam int AW = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic [7:0]    in_byte,
    input  logic [AW-1:0] station_addr,
    input  logic [1:0]    accept_mode,
    output logic          accept_o,
    output logic          reject_o
);
    logic [CW-1:0] byte_idx;
    logic          first_beat;
    logic          addr_beat;
    logic          last_beat;
    logic          short_abort;
    logic          frame_open;
    logic          stn_hit;
    logic          bc_hit;
    acc_mode_e     mode_hold;

    rxf_frame_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sof      (in_sof),
        .byte_idx    (byte_idx),
        .first_beat  (first_beat),
        .addr_beat   (addr_beat),
        .last_beat   (last_beat),
        .short_abort (short_abort),
        .frame_open  (frame_open)
    );

    rxf_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_byte      (in_byte),
        .station_addr (station_addr),
        .byte_idx     (byte_idx),
        .addr_beat    (addr_beat),
        .first_beat   (first_beat),
        .stn_hit      (stn_hit),
        .bc_hit       (bc_hit)
    );

    rxf_verdict u_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .first_beat  (first_beat),
        .last_beat   (last_beat),
        .short_abort (short_abort),
        .mode_in     (acc_mode_e'(accept_mode)),
        .stn_hit     (stn_hit),
        .bc_hit      (bc_hit),
        .accept_o    (accept_o),
        .reject_o    (reject_o),
        .mode_hold   (mode_hold)
    );
endmodule

// File: rtl/rxf_filter_chk.sv
// Property checker for rx_dest_filter; attached by the bind below.
// Assumes the bench holds rst_n low from time zero.
module rxf_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input logic       accept_o,
    input logic       reject_o,
    input logic       frame_open,
    input logic [1:0] mode_hold
);
    // R6
    excl_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept_o, reject_o}));

    // R6
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);

    // R7
    short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && frame_open) |=> (reject_o && !accept_o));

    // R2
    none_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ($past(mode_hold) != 2'd0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!accept_o && !reject_o));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!accept_o && !reject_o && !frame_open));
endmodule

bind rx_dest_filter rxf_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .accept_o   (accept_o),
    .reject_o   (reject_o),
    .frame_open (frame_open),
    .mode_hold  (mode_hold)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [47:0] station_addr = 48'h55_44_33_22_11_02;
    logic [1:0]  accept_mode = 2'd0;
    logic        accept_o;
    logic        reject_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [47:0] STN = 48'h55_44_33_22_11_02;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;

    // {mode, destination (byte 0 in bits 7..0), expect accept}
    localparam int NV = 11;
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, STN,                   1'b0},  // R2
        {2'd0, BC,                    1'b0},  // R2
        {2'd1, STN,                   1'b1},  // R3
        {2'd1, BC,                    1'b0},  // R3
        {2'd1, 48'h56_44_33_22_11_02, 1'b0},  // R3 last byte differs
        {2'd1, 48'h55_44_33_22_11_03, 1'b0},  // R1 first byte differs
        {2'd1, 48'h02_11_22_33_44_55, 1'b0},  // R1 reversed order
        {2'd2, STN,                   1'b1},  // R4
        {2'd2, BC,                    1'b1},  // R4
        {2'd2, 48'hFE_FF_FF_FF_FF_FF, 1'b0},  // R4 near broadcast
        {2'd3, 48'h9A_0C_7E_31_D4_08, 1'b1}   // R5
    };

    rx_dest_filter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_byte      (in_byte),
        .station_addr (station_addr),
        .accept_mode  (accept_mode),
        .accept_o     (accept_o),
        .reject_o     (reject_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: {accept,reject} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic acc, input logic rej);
        check({accept_o, reject_o} == {acc, rej}, req, {accept_o, reject_o}, {acc, rej});
    endtask

    // Present one byte for one cycle; returns at the next falling edge.
    task automatic push(input logic [7:0] b, input logic sof);
        in_valid = 1'b1;
        in_sof   = sof;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bytes first..last of dest, with quiet checks on the non-final ones.
    task automatic push_range(input logic [47:0] d, input int first, input int last, input string req);
        for (int i = first; i <= last; i++) begin
            push(d[8*i +: 8], i == 0);
            if (i != 5) expect_out(req, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL R6: watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        expect_out("R10 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(1);
        expect_out("R10 after reset", 1'b0, 1'b0);

        // Table walk over modes and address patterns
        for (int v = 0; v < NV; v++) begin
            accept_mode = VEC[v][50:49];
            push_range(VEC[v][48:1], 0, 5, "R6 early pulse");
            expect_out("R1-R5 table verdict", VEC[v][0], !VEC[v][0]);
            idle(1);
            expect_out("R6 one cycle", 1'b0, 1'b0);
        end

        // R9: gaps inside a frame
        accept_mode = 2'd1;
        for (int i = 0; i < 6; i++) begin
            push(STN[8*i +: 8], i == 0);
            if (i != 5) begin
                idle(2);
                expect_out("R9 gap", 1'b0, 1'b0);
            end
        end
        expect_out("R9 gapped accept", 1'b1, 1'b0);

        // R9: bytes after the sixth are ignored
        for (int i = 0; i < 4; i++) begin
            push(8'hFF, 1'b0);
            expect_out("R9 trailing byte", 1'b0, 1'b0);
        end

        // R9: bytes without a start while idle are ignored
        idle(1);
        push_range(STN, 1, 5, "R9 stray");
        push(8'h55, 1'b0);
        expect_out("R9 stray no pulse", 1'b0, 1'b0);

        // R7: truncated frame then a full one
        accept_mode = 2'd1;
        push_range(STN, 0, 2, "R7 short");
        push(STN[7:0], 1'b1);
        expect_out("R7 truncated reject", 1'b0, 1'b1);
        push_range(STN, 1, 5, "R7 new frame");
        expect_out("R7 restarted accept", 1'b1, 1'b0);
        idle(1);

        // R8: promiscuous frame, mode dropped to 0 mid-frame
        accept_mode = 2'd3;
        push_range(48'h01_02_03_04_05_06, 0, 1, "R8");
        accept_mode = 2'd0;
        push_range(48'h01_02_03_04_05_06, 2, 5, "R8");
        expect_out("R8 mode held 3", 1'b1, 1'b0);
        idle(1);

        // R8: mode 0 frame, raised to 3 mid-frame
        accept_mode = 2'd0;
        push_range(STN, 0, 2, "R8");
        accept_mode = 2'd3;
        push_range(STN, 3, 5, "R8");
        expect_out("R8 mode held 0", 1'b0, 1'b1);
        idle(1);

        // R10: reset mid-frame drops the open frame
        accept_mode = 2'd3;
        push_range(STN, 0, 2, "R10");
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        expect_out("R10 reset output", 1'b0, 1'b0);
        push_range(STN, 3, 4, "R10");
        push(STN[47:40], 1'b0);
        expect_out("R10 dropped frame", 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule